// File: doc/BRIEF.md
# Byte RAM host access port

This block holds a small byte-wide instruction RAM that belongs to an embedded microcontroller. It also gives a host processor a register window onto that RAM, through which the host loads the RAM's contents and reads them back. The host turns access on through a control register. It then polls a power-state field until the RAM reports awake. After that it works through two independent address pointers: one for writing and one for reading. Each pointer can step forward by one after every data access, so a run of bytes streams through one data register.

While host access is off, the RAM may drop into a dynamic sleep state. In that state the microcontroller reads the array through its own port. When host access is on, the host owns the array and the microcontroller's port returns zero. Multi-byte values, such as a 16-bit field held upper byte first, are fetched with consecutive auto-incrementing reads. Fixed bytes near the top of the array (offsets 0xF0 to 0xF6) are used for status information.

Top module: `iram_host_port`

## Requirements
- R1: After reset the control register reads 0, the power status reads 2 (asleep), and both address pointers read 0.
- R2: Control register (select 0) bit 0 is host-access enable, bit 1 is write auto-increment and bit 2 is read auto-increment. Each bit is written independently and reads back as written.
- R3: Power status (select 1, bits 1:0) reads 2 while access is disabled. In the cycle after the write that enables access it reads 1, and it stays 1 until WAKE_CYCLES clock edges have passed since that write; from then on it reads 0. Writing the enable bit again while it is already set does not restart the wait.
- R4: A write to select 2 loads the write pointer, and a read of select 2 returns it. When the RAM is awake, a write to select 3 stores the byte at the write pointer and, with write auto-increment on, advances the pointer by one.
- R5: With write auto-increment off, successive data writes all go to the same address and the write pointer does not move.
- R6: A write to select 4 loads the read pointer, and a read of select 4 returns it. When the RAM is awake, a read of select 5 returns the byte at the read pointer and, with read auto-increment on, advances the pointer by one. With read auto-increment off the pointer holds.
- R7: Both pointers wrap from 0xFF to 0x00 on auto-increment.
- R8: Data accesses (select 3 or 5) made while the status is not 0 are ignored: a write stores nothing, a read returns 0, and neither pointer moves. Pointer loads are accepted in any power state.
- R9: While host access is disabled, the microcontroller read port returns the byte at its address. While host access is enabled, that port returns 0.
- R10: Two consecutive auto-incrementing reads return adjacent bytes in address order, so a 16-bit value stored upper byte first at offsets 0xF2 and 0xF3 assembles correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, valid in the strobe cycle |
| uc_rd_addr | input | ADDR_W | Microcontroller read address |
| uc_rd_data | output | DATA_W | Microcontroller read data |

## Verification
The assertions check the following on every cycle:
- the status moves to waking when access is enabled and to asleep when it is disabled;
- data reads return zero and both pointers hold while the RAM is not awake;
- the write pointer steps by exactly one on an awake auto-incrementing write;
- the microcontroller port is blocked while the host owns the array.

Only the bench scenarios can show the following:
- the exact length of the wake delay;
- that bytes land at the right addresses and read back in order across the 0xFF wrap;
- that dropped writes left the array untouched;
- that a 16-bit value assembles from two reads.

// File: rtl/iram_host_port.sv
module iram_host_port #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int WAKE_CYCLES = 4,
  localparam int REG_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int CNT_W = $clog2(WAKE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [ADDR_W-1:0] uc_rd_addr,
  output logic [DATA_W-1:0] uc_rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_STAT = 3'd1, SEL_WPTR = 3'd2,
                         SEL_WDAT = 3'd3, SEL_RPTR = 3'd4, SEL_RDAT = 3'd5;
  localparam logic [1:0] PWR_ON = 2'd0, PWR_WAKING = 2'd1, PWR_SLEEP = 2'd2;

  logic              host_en, wr_inc, rd_inc;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0]  wake_cnt;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [1:0]        pwr_status;

  wire awake    = host_en && (wake_cnt == '0);
  wire ctrl_wr  = reg_wr && reg_addr == SEL_CTRL;
  wire wptr_wr  = reg_wr && reg_addr == SEL_WPTR;
  wire rptr_wr  = reg_wr && reg_addr == SEL_RPTR;
  wire wdat_acc = reg_wr && reg_addr == SEL_WDAT && awake;
  wire rdat_acc = reg_rd && reg_addr == SEL_RDAT && awake;
  wire en_rise  = ctrl_wr && reg_wdata[0] && !host_en;

  assign pwr_status = !host_en ? PWR_SLEEP : (wake_cnt != '0 ? PWR_WAKING : PWR_ON);
  assign uc_rd_data = host_en ? '0 : mem[uc_rd_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      host_en  <= 1'b0;
      wr_inc   <= 1'b0;
      rd_inc   <= 1'b0;
      wake_cnt <= '0;
      wptr     <= '0;
      rptr     <= '0;
    end else begin
      if (ctrl_wr) begin
        host_en <= reg_wdata[0];
        wr_inc  <= reg_wdata[1];
        rd_inc  <= reg_wdata[2];
      end
      if (en_rise)              wake_cnt <= CNT_W'(WAKE_CYCLES);
      else if (wake_cnt != '0)  wake_cnt <= wake_cnt - 1'b1;
      if (wptr_wr)              wptr <= reg_wdata[ADDR_W-1:0];
      else if (wdat_acc && wr_inc) wptr <= wptr + 1'b1;
      if (rptr_wr)              rptr <= reg_wdata[ADDR_W-1:0];
      else if (rdat_acc && rd_inc) rptr <= rptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (wdat_acc) mem[wptr] <= reg_wdata[DATA_W-1:0];

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        SEL_CTRL: reg_rdata = REG_W'({rd_inc, wr_inc, host_en});
        SEL_STAT: reg_rdata = REG_W'(pwr_status);
        SEL_WPTR: reg_rdata = REG_W'(wptr);
        SEL_RPTR: reg_rdata = REG_W'(rptr);
        SEL_RDAT: reg_rdata = awake ? REG_W'(mem[rptr]) : '0;
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/iram_host_port_chk.sv
module iram_host_port_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [2:0]        reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [DATA_W-1:0] uc_rd_data,
  input logic              host_en,
  input logic              wr_inc,
  input logic [ADDR_W-1:0] wptr,
  input logic [ADDR_W-1:0] rptr,
  input logic [1:0]        pwr_status
);
  wire ready = pwr_status == 2'd0;

  AST_WAKE_ON_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(host_en) |-> pwr_status == 2'd1); // R3
  AST_SLEEP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    $fell(host_en) |-> pwr_status == 2'd2); // R3
  AST_RDAT_ZERO_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd5 && !ready) |-> reg_rdata == '0); // R8
  AST_RPTR_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (!ready && !(reg_wr && reg_addr == 3'd4)) |=> $stable(rptr)); // R8
  AST_WPTR_HOLD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (!ready && !(reg_wr && reg_addr == 3'd2)) |=> $stable(wptr)); // R8
  AST_WPTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd3 && ready && wr_inc) |=> wptr == $past(wptr) + 1'b1); // R4
  AST_UC_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    host_en |-> uc_rd_data == '0); // R9
endmodule

bind iram_host_port iram_host_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .uc_rd_data(uc_rd_data), .host_en(host_en), .wr_inc(wr_inc),
  .wptr(wptr), .rptr(rptr), .pwr_status(pwr_status));

// File: tb/iram_host_port_bench.sv
module iram_host_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_WPTR = 3'd2,
                         A_WDAT = 3'd3, A_RPTR = 3'd4, A_RDAT = 3'd5;
  localparam int NV = 36;
  // {op, select, write data, expected read data, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {OP_RD,   A_CTRL, 8'h00, 8'h00, 4'd1},  // R1
    {OP_RD,   A_STAT, 8'h00, 8'h02, 4'd1},  // R1
    {OP_WR,   A_CTRL, 8'h07, 8'h00, 4'd2},
    {OP_RD,   A_CTRL, 8'h00, 8'h07, 4'd2},  // R2
    {OP_RD,   A_STAT, 8'h00, 8'h01, 4'd3},  // R3 waking
    {OP_IDLE, A_CTRL, 8'h00, 8'h00, 4'd3},
    {OP_RD,   A_STAT, 8'h00, 8'h01, 4'd3},  // R3 still waking
    {OP_RD,   A_STAT, 8'h00, 8'h00, 4'd3},  // R3 awake after 4 edges
    {OP_WR,   A_WPTR, 8'hFE, 8'h00, 4'd4},
    {OP_WR,   A_WDAT, 8'hA1, 8'h00, 4'd4},  // R4
    {OP_WR,   A_WDAT, 8'hB2, 8'h00, 4'd7},
    {OP_RD,   A_WPTR, 8'h00, 8'h00, 4'd7},  // R7 write wrap
    {OP_WR,   A_WDAT, 8'hC3, 8'h00, 4'd4},
    {OP_WR,   A_RPTR, 8'hFE, 8'h00, 4'd6},
    {OP_RD,   A_RDAT, 8'h00, 8'hA1, 4'd6},  // R6
    {OP_RD,   A_RDAT, 8'h00, 8'hB2, 4'd6},
    {OP_RD,   A_RDAT, 8'h00, 8'hC3, 4'd7},  // R7 read wrap
    {OP_RD,   A_RPTR, 8'h00, 8'h01, 4'd7},
    {OP_WR,   A_CTRL, 8'h01, 8'h00, 4'd5},
    {OP_WR,   A_WPTR, 8'h10, 8'h00, 4'd5},
    {OP_WR,   A_WDAT, 8'h11, 8'h00, 4'd5},
    {OP_WR,   A_WDAT, 8'h22, 8'h00, 4'd5},
    {OP_RD,   A_WPTR, 8'h00, 8'h10, 4'd5},  // R5
    {OP_WR,   A_RPTR, 8'h10, 8'h00, 4'd6},
    {OP_RD,   A_RDAT, 8'h00, 8'h22, 4'd5},  // R5 overwrite
    {OP_RD,   A_RDAT, 8'h00, 8'h22, 4'd6},
    {OP_RD,   A_RPTR, 8'h00, 8'h10, 4'd6},  // R6 no increment
    {OP_WR,   A_CTRL, 8'h07, 8'h00, 4'd3},
    {OP_RD,   A_STAT, 8'h00, 8'h00, 4'd3},  // R3 no restart
    {OP_WR,   A_CTRL, 8'h06, 8'h00, 4'd3},
    {OP_RD,   A_STAT, 8'h00, 8'h02, 4'd3},
    {OP_RD,   A_CTRL, 8'h00, 8'h06, 4'd2},
    {OP_RD,   A_RDAT, 8'h00, 8'h00, 4'd8},  // R8 read zero
    {OP_WR,   A_WDAT, 8'h55, 8'h00, 4'd8},
    {OP_RD,   A_WPTR, 8'h00, 8'h10, 4'd8},  // R8 pointers still
    {OP_RD,   A_RPTR, 8'h00, 8'h10, 4'd8}
  };

  logic clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, uc_rd_addr = '0;
  logic [7:0] reg_rdata, uc_rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  iram_host_port u_iram_host_port (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uc_rd_addr(uc_rd_addr),
    .uc_rd_data(uc_rd_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d,
                      input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_wr = (op == OP_WR); reg_rd = (op == OP_RD);
    reg_addr = a; reg_wdata = d;
    #1;
    if (op == OP_RD) cmp(req, reg_rdata, exp);
  endtask

  task automatic idle();
    step(OP_IDLE, A_CTRL, 8'h00, 8'h00, "");
  endtask

  task automatic uc_check(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    uc_rd_addr = a;
    #1 cmp(req, uc_rd_data, exp);
  endtask

  initial begin
    logic [15:0] word;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++)
      step(VEC[i][24:23], VEC[i][22:20], VEC[i][19:12], VEC[i][11:4],
           $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    idle();
    uc_check(8'hFE, 8'hA1, "R9 uc read while disabled");
    uc_check(8'h10, 8'h22, "R8 dropped write left byte");
    step(OP_WR, A_CTRL, 8'h07, 8'h00, "R3");
    uc_check(8'hFE, 8'h00, "R9 uc blocked while host enabled");
    step(OP_WR, A_WDAT, 8'h66, 8'h00, "R8");
    step(OP_RD, A_RDAT, 8'h00, 8'h00, "R8 read while waking");
    step(OP_RD, A_WPTR, 8'h00, 8'h10, "R8 wptr held while waking");
    idle(); idle();
    step(OP_RD, A_STAT, 8'h00, 8'h00, "R3 awake again");
    step(OP_RD, A_RDAT, 8'h00, 8'h22, "R8 waking write dropped");
    step(OP_WR, A_WPTR, 8'hF0, 8'h00, "R10");
    step(OP_WR, A_WDAT, 8'h03, 8'h00, "R10");
    step(OP_WR, A_WDAT, 8'h02, 8'h00, "R10");
    step(OP_WR, A_WDAT, 8'h07, 8'h00, "R10");
    step(OP_WR, A_WDAT, 8'hE4, 8'h00, "R10");
    step(OP_WR, A_RPTR, 8'hF2, 8'h00, "R10");
    step(OP_RD, A_RDAT, 8'h00, 8'h07, "R10 upper byte");
    word[15:8] = reg_rdata;
    step(OP_RD, A_RDAT, 8'h00, 8'hE4, "R10 lower byte");
    word[7:0] = reg_rdata;
    checks++;
    if (word !== 16'h07E4) begin
      fails++;
      $display("FAIL R10: word %04h expected 07e4", word);
    end
    step(OP_RD, A_RPTR, 8'h00, 8'hF4, "R6 pointer after pair");
    @(negedge clk); reg_rd = 0; reg_wr = 0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    step(OP_RD, A_CTRL, 8'h00, 8'h00, "R1 ctrl after reset");
    step(OP_RD, A_STAT, 8'h00, 8'h02, "R1 status after reset");
    step(OP_RD, A_WPTR, 8'h00, 8'h00, "R1 wptr after reset");
    step(OP_RD, A_RPTR, 8'h00, 8'h00, "R1 rptr after reset");
    idle();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule